// File: doc/BRIEF.md
# Zero-Page Indirect-Z Pointer Sequencer

This block generates addresses for a CPU core executing the zero-page indirect-indexed-by-Z addressing mode. It reads a little-endian pointer from zero page, starting at the operand byte, and adds the Z register to form the effective address. By default the pointer is two bytes wide. If the instruction comes directly after a NOP, the pointer is four bytes wide, which reaches a full 32-bit space. The wide form costs exactly two extra cycles.

Instructions arrive over a valid/ready handshake from the decoder. Every accepted instruction updates the prefix state, including those the sequencer does not act on. An indirect-Z instruction occupies the sequencer until it finishes. `op_ready` is low from the cycle after acceptance until the cycle in which `done` pulses, so the decoder must hold `op_valid` and its fields stable while `op_ready` is low. Zero-page memory is read with a strobe and returns its data one cycle after the strobe. Nothing in the read path can stall.

Top module: `zpind_seq`

## Requirements
- R1: Without the prefix, an indirect-Z instruction reads zero-page bytes at zp and zp+1, and the result is `{bank_hi, byte1, byte0}` plus Z.
- R2: When the accepted instruction just before is a NOP (`op_is_nop`=1), the instruction reads zp through zp+3. The result is the 32-bit value `{byte3, byte2, byte1, byte0}` plus Z. For example, bytes 0x28,0x00,0xF8,0x0F with Z=0 give 0x0FF80028.
- R3: `done` is a single-cycle pulse. It appears 4 cycles after the accepting clock edge in the narrow form and 6 cycles after it in the wide form.
- R4: Zero-page addresses wrap modulo 256. For example, zp=0xFE in the wide form reads 0xFE, 0xFF, 0x00, 0x01.
- R5: The prefix applies to one instruction only. A second indirect-Z instruction right after a prefixed one uses the narrow form.
- R6: A NOP followed by any instruction that is not indirect-Z has no effect on a later indirect-Z instruction.
- R7: `op_ready` is low while a pointer fetch is in progress. An instruction held valid during that time is not accepted and does not change the prefix state.
- R8: The addition of Z carries across the full 32-bit result. In the narrow form the carry goes into the bank half. In the wide form the result wraps modulo 2^32.
- R9: `mem_rd` is asserted exactly once per pointer byte, in ascending byte order. The first strobe comes in the cycle right after acceptance, and no other strobes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Decoder presents an instruction |
| op_ready | output | 1 | Sequencer can accept an instruction |
| op_is_nop | input | 1 | Presented instruction is a NOP |
| op_is_indz | input | 1 | Presented instruction uses indirect-Z addressing |
| op_zp | input | 8 | Zero-page operand byte |
| op_z | input | 8 | Z register value |
| bank_hi | input | 16 | Upper address half used by the narrow form |
| mem_addr | output | 8 | Zero-page read address |
| mem_rd | output | 1 | Read strobe, data returns next cycle |
| mem_rdata | input | 8 | Read data |
| ea | output | 32 | Effective address, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a two-byte narrow pointer, a four-byte wide pointer, an 8-bit zero page and a 32-bit result. These values cover the zero-page wrap at 0xFF. They also cover the carry from the narrow pointer into the bank half and the modulo-2^32 wrap of the wide form. Because both pointer widths are present, the bench can measure the exact two-cycle difference in latency and check the way the prefix arms and clears between consecutive instructions.

// File: rtl/zpind_pkg.sv
package zpind_pkg;
  localparam int ZP_W         = 8;
  localparam int BYTE_W       = 8;
  localparam int NARROW_BYTES = 2;
  localparam int WIDE_BYTES   = 4;
  localparam int EA_W         = WIDE_BYTES * BYTE_W;
  localparam int BANK_W       = EA_W - NARROW_BYTES * BYTE_W;
  localparam int CNT_W        = $clog2(WIDE_BYTES) + 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/zpind_prefix.sv
module zpind_prefix (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic acc_is_nop,
  output logic wide_sel
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (accept) armed_q <= acc_is_nop;
  end
  assign wide_sel = armed_q;
endmodule

// File: rtl/zpind_fetch.sv
module zpind_fetch
  import zpind_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wide,
  input  logic [ZP_W-1:0] start_zp,
  output logic            busy,
  output logic            rd,
  output logic [ZP_W-1:0] rd_addr,
  output logic            cap_en,
  output cnt_t            cap_idx,
  output logic            cap_last
);
  logic            busy_q, wide_q, pend_q;
  logic [ZP_W-1:0] zp_q;
  cnt_t            iss_q, cap_q, nbytes;

  assign nbytes   = wide_q ? cnt_t'(WIDE_BYTES) : cnt_t'(NARROW_BYTES);
  assign rd       = busy_q && (iss_q < nbytes);
  assign rd_addr  = zp_q + ZP_W'(iss_q);
  assign cap_en   = pend_q;
  assign cap_idx  = cap_q;
  assign cap_last = pend_q && (cap_q == nbytes - cnt_t'(1));
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wide_q <= 1'b0;
      pend_q <= 1'b0;
      zp_q   <= '0;
      iss_q  <= '0;
      cap_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      wide_q <= start_wide;
      pend_q <= 1'b0;
      zp_q   <= start_zp;
      iss_q  <= '0;
      cap_q  <= '0;
    end else if (busy_q) begin
      pend_q <= rd;
      if (rd)       iss_q  <= iss_q + cnt_t'(1);
      if (pend_q)   cap_q  <= cap_q + cnt_t'(1);
      if (cap_last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/zpind_assemble.sv
module zpind_assemble
  import zpind_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wide,
  input  logic [BYTE_W-1:0] start_z,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              cap_en,
  input  cnt_t              cap_idx,
  input  logic              cap_last,
  input  logic [BYTE_W-1:0] rdata,
  output logic [EA_W-1:0]   ea,
  output logic              done
);
  logic [EA_W-1:0]   ptr_q, ptr_next, base, ea_q;
  logic [BYTE_W-1:0] z_q;
  logic [BANK_W-1:0] bank_q;
  logic              wide_q, done_q;

  always_comb begin
    ptr_next = ptr_q;
    for (int b = 0; b < WIDE_BYTES; b++)
      if (cap_en && cap_idx == cnt_t'(b)) ptr_next[b*BYTE_W +: BYTE_W] = rdata;
  end

  assign base = wide_q ? ptr_next
                       : {bank_q, ptr_next[NARROW_BYTES*BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      z_q    <= '0;
      bank_q <= '0;
      wide_q <= 1'b0;
      ea_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        ptr_q  <= '0;
        z_q    <= start_z;
        bank_q <= start_bank;
        wide_q <= start_wide;
      end else begin
        ptr_q <= ptr_next;
        if (cap_last) begin
          ea_q   <= base + EA_W'(z_q);
          done_q <= 1'b1;
        end
      end
    end
  end
  assign ea   = ea_q;
  assign done = done_q;
endmodule

// File: rtl/zpind_seq.sv
module zpind_seq
  import zpind_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_is_nop,
  input  logic              op_is_indz,
  input  logic [ZP_W-1:0]   op_zp,
  input  logic [BYTE_W-1:0] op_z,
  input  logic [BANK_W-1:0] bank_hi,
  output logic [ZP_W-1:0]   mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [EA_W-1:0]   ea,
  output logic              done
);
  logic busy, accept, start, wide_sel, cap_en, cap_last;
  cnt_t cap_idx;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign start    = accept && op_is_indz;

  zpind_prefix u_prefix (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .acc_is_nop(op_is_nop), .wide_sel(wide_sel)
  );

  zpind_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wide(wide_sel),
    .start_zp(op_zp), .busy(busy), .rd(mem_rd), .rd_addr(mem_addr),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_last(cap_last)
  );

  zpind_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wide(wide_sel),
    .start_z(op_z), .start_bank(bank_hi), .cap_en(cap_en),
    .cap_idx(cap_idx), .cap_last(cap_last), .rdata(mem_rdata),
    .ea(ea), .done(done)
  );
endmodule

// File: rtl/zpind_seq_chk.sv
module zpind_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic       op_is_indz,
  input logic [7:0] op_zp,
  input logic [7:0] mem_addr,
  input logic       mem_rd,
  input logic       done
);
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !op_ready);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr == 8'($past(mem_addr) + 8'd1));

  assert_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_is_indz) |=> (mem_rd && mem_addr == $past(op_zp)));

  assert_done_after_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !$past(mem_rd) && $past(mem_rd, 2)));
endmodule

bind zpind_seq zpind_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_is_indz(op_is_indz), .op_zp(op_zp), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .done(done)
);

// File: tb/tb_zpind_seq.sv
module tb_zpind_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 0, op_is_nop = 0, op_is_indz = 0;
  logic [7:0]  op_zp = 0, op_z = 0;
  logic [15:0] bank_hi = 0;
  logic        op_ready, mem_rd, done;
  logic [7:0]  mem_addr, mem_rdata;
  logic [31:0] ea;

  int errors = 0, checks = 0, cyc = 0, acc_cyc = 0, done_cyc = 0, ndone = 0, ntr = 0;
  logic [31:0] ea_seen;
  logic [7:0]  zpm [0:255];
  logic [7:0]  tr  [0:15];
  bit finished = 0;

  always #4 clk = ~clk;

  zpind_seq dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      mem_rdata <= zpm[mem_addr];
      if (ntr < 16) tr[ntr] <= mem_addr;
      ntr <= ntr + 1;
    end
    if (op_valid && op_ready) acc_cyc <= cyc;
    if (done) begin done_cyc <= cyc; ea_seen <= ea; ndone <= ndone + 1; end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit nop, input bit indz, input logic [7:0] zp,
                       input logic [7:0] z, input logic [15:0] bank);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1; op_is_nop = nop; op_is_indz = indz;
    op_zp = zp; op_z = z; bank_hi = bank;
    @(negedge clk);
    op_valid = 0; op_is_nop = 0; op_is_indz = 0;
  endtask

  task automatic indz_run(input logic [7:0] zp, input logic [7:0] z, input logic [15:0] bank,
                          input bit wide, input logic [31:0] exp_ea, input string tag);
    int d0, n;
    d0 = ndone;
    ntr = 0;
    issue(0, 1, zp, z, bank);
    for (int i = 0; i < 20 && ndone == d0; i++) @(negedge clk);
    n = wide ? 4 : 2;
    check(ndone == d0 + 1, {tag, " done count"}, ndone - d0, 1);
    check(ea_seen == exp_ea, {tag, " ea"}, ea_seen, exp_ea);
    check(done_cyc - acc_cyc == (wide ? 6 : 4), "R3 latency", done_cyc - acc_cyc, wide ? 6 : 4);
    check(ntr == n, "R9 read count", ntr, n);
    for (int i = 0; i < n && i < 16; i++)
      check(tr[i] == 8'(zp + i), "R4/R9 read order", tr[i], 8'(zp + i));
  endtask

  task automatic t_reset();
    check(op_ready == 1'b1, "R7 reset ready", op_ready, 1);
    check(done == 1'b0, "R3 reset done", done, 0);
    check(mem_rd == 1'b0, "R9 reset strobe", mem_rd, 0);
  endtask

  task automatic t_narrow();
    zpm[8'h10] = 8'h34; zpm[8'h11] = 8'h12;
    indz_run(8'h10, 8'h05, 16'hABCD, 0, 32'hABCD1239, "R1 narrow");
  endtask

  task automatic t_wide_example();
    zpm[8'h40] = 8'h28; zpm[8'h41] = 8'h00; zpm[8'h42] = 8'hF8; zpm[8'h43] = 8'h0F;
    issue(1, 0, 0, 0, 0);
    indz_run(8'h40, 8'h00, 16'h5555, 1, 32'h0FF80028, "R2 wide");
  endtask

  task automatic t_zp_wrap();
    zpm[8'hFE] = 8'h01; zpm[8'hFF] = 8'h02; zpm[8'h00] = 8'h03; zpm[8'h01] = 8'h04;
    issue(1, 0, 0, 0, 0);
    indz_run(8'hFE, 8'h10, 16'h0, 1, 32'h04030211, "R4 wrap");
  endtask

  task automatic t_one_shot();
    zpm[8'h20] = 8'hAA; zpm[8'h21] = 8'hBB; zpm[8'h22] = 8'hCC; zpm[8'h23] = 8'hDD;
    issue(1, 0, 0, 0, 0);
    indz_run(8'h20, 8'h00, 16'h0001, 1, 32'hDDCCBBAA, "R5 prefixed");
    indz_run(8'h20, 8'h00, 16'h0001, 0, 32'h0001BBAA, "R5 after prefixed");
  endtask

  task automatic t_nop_other();
    issue(1, 0, 0, 0, 0);
    issue(0, 0, 8'h77, 0, 0);
    indz_run(8'h20, 8'h01, 16'h0002, 0, 32'h0002BBAB, "R6 stale nop");
  endtask

  task automatic t_busy_block();
    int d0, bad;
    d0 = ndone; bad = 0;
    issue(0, 1, 8'h20, 8'h00, 16'h0003);
    op_valid = 1; op_is_nop = 1;
    for (int i = 0; i < 3; i++) begin
      if (op_ready) bad++;
      @(negedge clk);
    end
    op_valid = 0; op_is_nop = 0;
    for (int i = 0; i < 10 && ndone == d0; i++) @(negedge clk);
    check(bad == 0, "R7 ready low while busy", bad, 0);
    indz_run(8'h20, 8'h00, 16'h0003, 0, 32'h0003BBAA, "R7 held nop ignored");
  endtask

  task automatic t_carry();
    zpm[8'h50] = 8'hFF; zpm[8'h51] = 8'hFF; zpm[8'h52] = 8'hFF; zpm[8'h53] = 8'hFF;
    indz_run(8'h50, 8'h01, 16'h0012, 0, 32'h00130000, "R8 narrow carry");
    issue(1, 0, 0, 0, 0);
    indz_run(8'h50, 8'h02, 16'h0012, 1, 32'h00000001, "R8 wide wrap");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) zpm[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_narrow();
    t_wide_example();
    t_zp_wrap();
    t_one_shot();
    t_nop_other();
    t_busy_block();
    t_carry();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule